// File: doc/BRIEF.md
# Memory Ordering Barrier Gate

This block sits between a core that sends memory requests in program order and a memory system that may finish them in any order. Each request carries a kind: plain load, plain store, load-acquire, store-release, ordering barrier, completion barrier, maintenance operation or non-memory operation. The gate either passes the request to the memory port or consumes it, and it raises a stall towards the core whenever the request at the head of the stream may not move yet.

The gate tracks unfinished work with three pieces of state. One saturating counter holds the plain loads, plain stores and store-releases that are issued but not finished. A second saturating counter holds the unfinished maintenance operations. A flag marks a load-acquire in flight. Memory reports each finished access on one of three single-cycle completion inputs: one for counted accesses, one for maintenance operations and one for the acquire. An ordering barrier only needs the earlier accesses to have been accepted by the memory port. Because the port is passed through in order, that barrier never waits. A completion barrier waits until everything earlier has finished.

Top module: `mem_order_gate`

## Requirements
- R1: After reset nothing is outstanding, so a completion barrier presented first is consumed in the same cycle, with no stall and no issue.
- R2: Kind codes are 0 load, 1 store, 2 load-acquire, 3 store-release, 4 ordering barrier, 5 completion barrier, 6 maintenance, 7 non-memory. Kinds 0, 1, 2, 3 and 6, when allowed, drive iss_valid in the same cycle with iss_kind equal to req_kind. The request stalls while iss_ready is low.
- R3: An ordering barrier is consumed in the cycle it is presented and never appears on the issue port, even while accesses are outstanding.
- R4: A completion barrier stalls until the access counter and the maintenance counter are both zero and no acquire is in flight. It is consumed in the first cycle all three hold.
- R5: A non-memory request (kind 7) is consumed without stall while accesses are outstanding.
- R6: While a load-acquire is in flight, kinds 0 to 3 stall and maintenance still issues. A pulse on acq_done releases the hold from the next cycle.
- R7: A load-acquire issues even when earlier accesses are still outstanding.
- R8: A store-release issues only when the access counter is zero and no acquire is in flight.
- R9: An access that follows a store-release issues while the release is still outstanding.
- R10: The access counter saturates at MEM_MAX. Further loads, stores and releases stall until a mem_done pulse frees a slot.
- R11: The maintenance counter saturates at MAINT_MAX. Further maintenance stalls until a maint_done pulse frees a slot.
- R12: Completion pulses that arrive when nothing of that class is outstanding have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core presents a request |
| req_kind | input | 3 | Request kind code |
| req_stall | output | 1 | Head request cannot move this cycle |
| iss_valid | output | 1 | Request offered to memory |
| iss_kind | output | 3 | Kind of the offered request |
| iss_ready | input | 1 | Memory accepts the offered request |
| mem_done | input | 1 | One counted access finished |
| maint_done | input | 1 | One maintenance operation finished |
| acq_done | input | 1 | The in-flight load-acquire finished |

## Verification
The bench drains the access counter one pulse at a time under a waiting release and a waiting completion barrier. A gate that compared against a stale count would let either of them through one cycle early. It checks that an acquire in flight blocks a release even when the counter reads zero, that maintenance slips past an acquire, and that a completion barrier also waits for the maintenance counter. Each counter is filled to its limit to show that the next request stalls. A design whose counter wrapped would let it through. Stray completion pulses on an idle gate must leave a later completion barrier unstalled, which catches a counter that underflows.

// File: rtl/mem_order_gate.sv
module mem_order_gate #(
  parameter int MEM_MAX   = 6,
  parameter int MAINT_MAX = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [2:0] req_kind,
  output logic       req_stall,
  output logic       iss_valid,
  output logic [2:0] iss_kind,
  input  logic       iss_ready,
  input  logic       mem_done,
  input  logic       maint_done,
  input  logic       acq_done
);
  localparam int MW = $clog2(MEM_MAX + 1);
  localparam int XW = $clog2(MAINT_MAX + 1);
  localparam logic [2:0] K_LD = 3'd0, K_ST = 3'd1, K_ACQ = 3'd2, K_REL = 3'd3,
                         K_DSB = 3'd5, K_MNT = 3'd6;

  logic [MW-1:0] mem_cnt;
  logic [XW-1:0] mnt_cnt;
  logic          acq_pend;

  wire is_acc  = (req_kind == K_LD) || (req_kind == K_ST) || (req_kind == K_REL);
  wire is_mem  = is_acc || (req_kind == K_ACQ);
  wire is_mnt  = (req_kind == K_MNT);
  wire to_port = is_mem || is_mnt;
  wire mem_full = (mem_cnt == MW'(MEM_MAX));
  wire mnt_full = (mnt_cnt == XW'(MAINT_MAX));
  wire idle     = (mem_cnt == '0) && (mnt_cnt == '0) && !acq_pend;

  wire blocked = (is_mem && acq_pend)
              || (is_acc && mem_full)
              || ((req_kind == K_REL) && (mem_cnt != '0))
              || (is_mnt && mnt_full)
              || ((req_kind == K_DSB) && !idle);

  wire go = req_valid && !blocked && (!to_port || iss_ready);

  assign req_stall = req_valid && !go;
  assign iss_valid = req_valid && to_port && !blocked;
  assign iss_kind  = req_kind;

  wire mem_inc = go && is_acc;
  wire mem_dec = mem_done && (mem_cnt != '0);
  wire mnt_inc = go && is_mnt;
  wire mnt_dec = maint_done && (mnt_cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_cnt  <= '0;
      mnt_cnt  <= '0;
      acq_pend <= 1'b0;
    end else begin
      mem_cnt <= mem_cnt + MW'(mem_inc) - MW'(mem_dec);
      mnt_cnt <= mnt_cnt + XW'(mnt_inc) - XW'(mnt_dec);
      if (go && (req_kind == K_ACQ)) acq_pend <= 1'b1;
      else if (acq_done)             acq_pend <= 1'b0;
    end
  end

  // R10
  mem_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cnt <= MW'(MEM_MAX));

  // R11
  mnt_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mnt_cnt <= XW'(MAINT_MAX));

  // R8
  rel_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_kind == K_REL) |-> (mem_cnt == '0 && !acq_pend));

  // R6
  acq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acq_pend && iss_valid) |-> (iss_kind == K_MNT));

  // R4
  dsb_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == K_DSB && !req_stall) |-> idle);

  // R3
  dmb_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 3'd4) |-> (!req_stall && !iss_valid));
endmodule

// File: tb/test_mem_order_gate.sv
module test_mem_order_gate;
  localparam int PER = 10;
  localparam int MEM_MAX = 6;
  localparam int MAINT_MAX = 3;
  localparam logic [2:0] LD = 0, ST = 1, ACQ = 2, REL = 3, DMB = 4, DSB = 5, MNT = 6, NOP = 7;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, iss_ready = 0, mem_done = 0, maint_done = 0, acq_done = 0;
  logic [2:0] req_kind = NOP;
  logic req_stall, iss_valid;
  logic [2:0] iss_kind;
  int checks = 0, errors = 0;
  bit finished = 0;

  mem_order_gate #(.MEM_MAX(MEM_MAX), .MAINT_MAX(MAINT_MAX)) i_mem_order_gate (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_stall(req_stall), .iss_valid(iss_valid), .iss_kind(iss_kind),
    .iss_ready(iss_ready), .mem_done(mem_done), .maint_done(maint_done),
    .acq_done(acq_done));

  always #(PER/2) clk = ~clk;

  function automatic logic [14:0] row(bit v, logic [2:0] k, bit rdy, bit md, bit xd,
                                      bit ad, bit es, bit ei, int r);
    return {v, k, rdy, md, xd, ad, es, ei, r[4:0]};
  endfunction

  localparam int N = 26;
  localparam logic [14:0] TBL [N] = '{
    row(1, DSB, 1, 0, 0, 0, 0, 0, 1),  // R1
    row(1, LD,  1, 0, 0, 0, 0, 1, 2),  // R2
    row(1, ST,  0, 0, 0, 0, 1, 1, 2),  // R2
    row(1, ST,  1, 0, 0, 0, 0, 1, 2),  // R2
    row(1, DMB, 0, 0, 0, 0, 0, 0, 3),  // R3
    row(1, NOP, 0, 0, 0, 0, 0, 0, 5),  // R5
    row(1, REL, 1, 0, 0, 0, 1, 0, 8),  // R8
    row(1, REL, 1, 1, 0, 0, 1, 0, 8),  // R8
    row(1, REL, 1, 1, 0, 0, 1, 0, 8),  // R8
    row(1, REL, 1, 0, 0, 0, 0, 1, 8),  // R8
    row(1, LD,  1, 0, 0, 0, 0, 1, 9),  // R9
    row(1, ACQ, 1, 0, 0, 0, 0, 1, 7),  // R7
    row(1, LD,  1, 0, 0, 0, 1, 0, 6),  // R6
    row(1, MNT, 1, 0, 0, 0, 0, 1, 6),  // R6
    row(1, DSB, 1, 0, 0, 1, 1, 0, 4),  // R4
    row(1, DSB, 1, 1, 0, 0, 1, 0, 4),  // R4
    row(1, DSB, 1, 1, 0, 0, 1, 0, 4),  // R4
    row(1, DSB, 1, 0, 1, 0, 1, 0, 4),  // R4
    row(1, DSB, 1, 0, 0, 0, 0, 0, 4),  // R4
    row(1, LD,  1, 0, 0, 0, 0, 1, 6),  // R6
    row(0, NOP, 1, 1, 1, 1, 0, 0, 12), // R12
    row(1, DSB, 1, 0, 0, 0, 0, 0, 12), // R12
    row(1, ACQ, 1, 0, 0, 0, 0, 1, 7),  // R7
    row(1, REL, 1, 0, 0, 1, 1, 0, 8),  // R8
    row(1, REL, 1, 0, 0, 0, 0, 1, 8),  // R8
    row(0, NOP, 1, 1, 0, 0, 0, 0, 12)  // R12
  };

  task automatic step(bit v, logic [2:0] k, bit rdy, bit md, bit xd, bit ad,
                      bit es, bit ei, int r);
    @(negedge clk);
    req_valid = v; req_kind = k; iss_ready = rdy;
    mem_done = md; maint_done = xd; acq_done = ad;
    #1;
    checks++;
    if (req_stall !== es || iss_valid !== ei || (ei && iss_kind !== k)) begin
      errors++;
      $display("FAIL R%0d: stall=%b iss=%b kind=%0d expected stall=%b iss=%b kind=%0d",
               r, req_stall, iss_valid, iss_kind, es, ei, k);
    end
  endtask

  task automatic reset_gate();
    @(negedge clk);
    rst_n = 0; req_valid = 0; mem_done = 0; maint_done = 0; acq_done = 0;
    @(negedge clk);
    rst_n = 1;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(PER * 200000);
    errors++;
    $display("FAIL watchdog: run did not end");
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    // R1: reset state, nothing offered, nothing stalled
    step(0, NOP, 1, 0, 0, 0, 0, 0, 1);
    for (int i = 0; i < N; i++) begin
      logic [14:0] t;
      t = TBL[i];
      step(t[14], t[13:11], t[10], t[9], t[8], t[7], t[6], t[5], int'(t[4:0]));
    end

    // R10: fill access counter to its cap
    reset_gate();
    for (int i = 0; i < MEM_MAX; i++) step(1, ST, 1, 0, 0, 0, 0, 1, 10);
    step(1, LD, 1, 0, 0, 0, 1, 0, 10);
    step(1, LD, 1, 1, 0, 0, 1, 0, 10);
    step(1, LD, 1, 0, 0, 0, 0, 1, 10);
    step(1, LD, 1, 0, 0, 0, 1, 0, 10);

    // R11: fill maintenance counter to its cap
    reset_gate();
    for (int i = 0; i < MAINT_MAX; i++) step(1, MNT, 1, 0, 0, 0, 0, 1, 11);
    step(1, MNT, 1, 0, 0, 0, 1, 0, 11);
    step(1, LD, 1, 0, 0, 0, 0, 1, 11);
    step(1, MNT, 1, 0, 1, 0, 1, 0, 11);
    step(1, MNT, 1, 0, 0, 0, 0, 1, 11);
    // R4: completion barrier waits on maintenance and accesses
    step(1, DSB, 1, 1, 1, 0, 1, 0, 4);
    step(1, DSB, 1, 0, 1, 0, 1, 0, 4);
    step(1, DSB, 1, 0, 1, 0, 1, 0, 4);
    step(1, DSB, 1, 0, 0, 0, 0, 0, 4);

    // R1: reset clears an in-flight acquire
    step(1, ACQ, 1, 0, 0, 0, 0, 1, 7);
    reset_gate();
    step(1, LD, 1, 0, 0, 0, 0, 1, 1);

    @(negedge clk);
    req_valid = 0;
    finish_run();
  end
endmodule